// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point words, each made of a sign, an 8-bit biased exponent (bias 127) and a 23-bit fraction with an implied leading one. A control input turns the operation into a subtraction by inverting the sign of the second operand. The operand with the larger magnitude sets the sign and the starting exponent. The other significand is shifted right to line up with it, and the shifted-out bits are kept as guard, round and sticky bits. The two significands are then summed or differenced, normalized in either direction and rounded to nearest with ties to even.

Special operands do not go through the arithmetic path. Separate logic handles zero, infinity and NaN operands. Subnormal operands are read as zero, and results too small for the normal range are flushed to a signed zero. The block takes one operand pair per cycle. Each result appears one clock after its inputs are presented, together with overflow, underflow, invalid and inexact flags.

Top module: `fp_addsub`

## Requirements
- R1: Finite normal operands produce a result rounded to nearest, ties to even. Examples: 1.0 + 1.5·2^-24 gives 0x3F800001; 1.0 + 2^-24 (a tie with an even LSB) gives 0x3F800000; 0x3F800001 + 2^-24 (a tie with an odd LSB) gives 0x3F800002.
- R2: When sub_en is 1, the sign of op_b is inverted before the operation. When the effective signs differ, the magnitudes are subtracted. The sum is shifted left until its leading bit is 1, and the exponent is reduced by the same count. Example: 0x3F800001 - 0x3F800000 gives 0x34000000.
- R3: A carry out of the significand sum shifts the sum right by one and adds 1 to the exponent; the bit shifted out feeds rounding. A rounding carry out of an all-ones significand renormalizes. Example: 0x3FFFFFFF + 2^-24 gives 0x40000000.
- R4: Subtracting equal magnitudes gives +0 (0x00000000) with all flags clear.
- R5: If the biased exponent after rounding is above 254, the result is a signed infinity (exponent field all ones, fraction 0), and flag_ovf and flag_inx are both 1.
- R6: If the biased exponent after rounding is below 1, the result is a signed zero, and flag_unf and flag_inx are both 1. An operand with exponent field 0 is treated as zero, so no result is ever subnormal.
- R7: For a finite nonzero result, flag_inx is 1 exactly when any of the discarded guard, round or sticky bits is nonzero. At most one of flag_ovf, flag_unf and flag_inv is set.
- R8: If either operand is a NaN (exponent all ones, fraction nonzero), the result is 0x7FC00000 with no flags. Infinities of opposite effective sign give 0x7FC00000 with only flag_inv set.
- R9: An infinity combined with a finite operand returns that infinity with its effective sign. A zero operand returns the other operand, with the effective sign applied to op_b. Two zeros give a zero whose sign is the AND of the two effective signs. No flags are raised in any of these cases.
- R10: Results and flags are registered. They appear in the cycle after in_valid is high, with out_valid high. When in_valid is low, out_valid goes low in the next cycle and result holds its value. Reset clears out_valid, result and all flags to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are valid this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| sub_en | input | 1 | 1 = subtract op_b, 0 = add |
| out_valid | output | 1 | Result is valid |
| result | output | 32 | Rounded sum or difference |
| flag_ovf | output | 1 | Overflow to infinity |
| flag_unf | output | 1 | Underflow flushed to zero |
| flag_inv | output | 1 | Invalid operation (opposite infinities) |
| flag_inx | output | 1 | Result is not exact |

## Verification
The bench targets the rounding boundary cases: exact ties with even and odd LSBs, a tie that carries out of an all-ones significand, and an operand far below the other that leaves only a sticky bit. A design that rounds ties away from zero, or that drops the sticky bit, returns a result one ULP off in these cases. Deep cancellation and an exact cancel are driven to catch a wrong leading-zero count, a wrong exponent adjustment, and a negative zero. Overflow at the top of the range and underflow in both signs are driven to check for a missing flush or a missing flag. Opposite infinities, NaN and zero operands check that the special-operand path wins over the arithmetic path and applies the subtract control to the sign of the second operand.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

    localparam int FP_EXP_W  = 8;
    localparam int FP_FRAC_W = 23;
    localparam int FP_GRS_W  = 3;

    typedef enum logic [1:0] {
        CLS_ZERO   = 2'd0,
        CLS_FINITE = 2'd1,
        CLS_INF    = 2'd2,
        CLS_NAN    = 2'd3
    } fp_class_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inv;
        logic inx;
    } fp_flags_t;

endpackage

// File: rtl/fpadd_classify.sv
module fpadd_classify
    import fpadd_pkg::*;
#(
    parameter int EW = FP_EXP_W,
    parameter int FW = FP_FRAC_W
) (
    input  logic [EW+FW:0] word_i,
    input  logic           negate_i,
    output logic           sign_o,
    output logic [EW-1:0]  exp_o,
    output logic [FW:0]    sig_o,
    output fp_class_e      cls_o
);

    logic [EW-1:0] e_fld;
    logic [FW-1:0] f_fld;

    assign e_fld  = word_i[EW+FW-1:FW];
    assign f_fld  = word_i[FW-1:0];
    assign sign_o = word_i[EW+FW] ^ negate_i;
    assign exp_o  = e_fld;
    assign sig_o  = {1'b1, f_fld};

    always_comb begin
        if (e_fld == '0)
            cls_o = CLS_ZERO;
        else if (&e_fld)
            cls_o = (|f_fld) ? CLS_NAN : CLS_INF;
        else
            cls_o = CLS_FINITE;
    end

endmodule

// File: rtl/fpadd_align.sv
module fpadd_align
    import fpadd_pkg::*;
#(
    parameter int EW = FP_EXP_W,
    parameter int FW = FP_FRAC_W
) (
    input  logic              sign_a,
    input  logic [EW-1:0]     exp_a,
    input  logic [FW:0]       sig_a,
    input  logic              sign_b,
    input  logic [EW-1:0]     exp_b,
    input  logic [FW:0]       sig_b,
    output logic              big_sign,
    output logic [EW-1:0]     big_exp,
    output logic [FW+FP_GRS_W:0] big_ext,
    output logic [FW+FP_GRS_W:0] small_ext,
    output logic              eff_sub
);

    localparam int P    = FW + 1;
    localparam int XW   = P + FP_GRS_W;
    localparam int WIDE = P + XW;
    localparam int SW   = $clog2(XW + 1);

    logic          a_is_big;
    logic [EW-1:0] small_exp;
    logic [FW:0]   big_sig;
    logic [FW:0]   small_sig;
    logic [EW-1:0] diff;
    logic [SW-1:0] sh;
    logic [WIDE-1:0] wide;

    // magnitude order: exponent first, then fraction
    assign a_is_big  = {exp_a, sig_a[FW-1:0]} >= {exp_b, sig_b[FW-1:0]};
    assign big_sign  = a_is_big ? sign_a : sign_b;
    assign big_exp   = a_is_big ? exp_a  : exp_b;
    assign small_exp = a_is_big ? exp_b  : exp_a;
    assign big_sig   = a_is_big ? sig_a  : sig_b;
    assign small_sig = a_is_big ? sig_b  : sig_a;
    assign eff_sub   = sign_a ^ sign_b;
    assign diff      = big_exp - small_exp;

    // beyond XW positions the whole small significand is sticky
    always_comb begin
        if (int'(diff) > XW)
            sh = SW'(XW);
        else
            sh = diff[SW-1:0];
    end

    assign wide      = {small_sig, {XW{1'b0}}} >> sh;
    assign big_ext   = {big_sig, {FP_GRS_W{1'b0}}};
    assign small_ext = {wide[WIDE-1:P+1], wide[P] | (|wide[P-1:0])};

endmodule

// File: rtl/fpadd_normround.sv
module fpadd_normround
    import fpadd_pkg::*;
#(
    parameter int EW = FP_EXP_W,
    parameter int FW = FP_FRAC_W
) (
    input  logic                 eff_sub,
    input  logic                 big_sign,
    input  logic [EW-1:0]        big_exp,
    input  logic [FW+FP_GRS_W:0] big_ext,
    input  logic [FW+FP_GRS_W:0] small_ext,
    output logic                 res_sign,
    output logic [EW-1:0]        res_exp,
    output logic [FW-1:0]        res_frac,
    output logic                 exact_zero,
    output logic                 ovf,
    output logic                 unf,
    output logic                 inx
);

    localparam int P   = FW + 1;
    localparam int XW  = P + FP_GRS_W;
    localparam int LW  = $clog2(XW + 1);
    localparam int EXW = EW + 2;
    localparam logic signed [EXW-1:0] EMAX = EXW'((1 << EW) - 1);
    localparam logic signed [EXW-1:0] EONE = EXW'(1);

    logic [XW:0]   sum;
    logic [LW-1:0] lz;
    logic [XW-1:0] norm;
    logic signed [EXW-1:0] e_n;
    logic signed [EXW-1:0] e_r;
    logic          lsb_b, rnd_b, stk_b, up;
    logic [P:0]    m_r;
    logic [P-1:0]  mant;

    assign sum = eff_sub ? ({1'b0, big_ext} - {1'b0, small_ext})
                         : ({1'b0, big_ext} + {1'b0, small_ext});

    // leading-zero count of the low XW bits; highest set bit wins
    always_comb begin
        lz = LW'(XW);
        for (int i = 0; i < XW; i++) begin
            if (sum[i])
                lz = LW'(XW - 1 - i);
        end
    end

    always_comb begin
        if (sum[XW]) begin
            norm = {sum[XW:2], sum[1] | sum[0]};
            e_n  = $signed({2'b00, big_exp}) + EONE;
        end else begin
            norm = sum[XW-1:0] << lz;
            e_n  = $signed({2'b00, big_exp}) - $signed({{(EXW-LW){1'b0}}, lz});
        end
    end

    assign lsb_b = norm[FP_GRS_W];
    assign rnd_b = norm[FP_GRS_W-1];
    assign stk_b = |norm[FP_GRS_W-2:0];
    assign up    = rnd_b & (lsb_b | stk_b);
    assign m_r   = {1'b0, norm[XW-1:FP_GRS_W]} + (P+1)'(up);

    always_comb begin
        if (m_r[P]) begin
            mant = m_r[P:1];
            e_r  = e_n + EONE;
        end else begin
            mant = m_r[P-1:0];
            e_r  = e_n;
        end
    end

    assign exact_zero = (sum == '0);
    assign ovf        = !exact_zero && (e_r >= EMAX);
    assign unf        = !exact_zero && (e_r < EONE);
    assign inx        = !exact_zero && (rnd_b | stk_b | ovf | unf);
    assign res_sign   = exact_zero ? 1'b0 : big_sign;
    assign res_exp    = e_r[EW-1:0];
    assign res_frac   = mant[FW-1:0];

endmodule

// File: rtl/fp_addsub.sv
module fp_addsub
    import fpadd_pkg::*;
#(
    parameter int EW = FP_EXP_W,
    parameter int FW = FP_FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [EW+FW:0] op_a,
    input  logic [EW+FW:0] op_b,
    input  logic          sub_en,
    output logic          out_valid,
    output logic [EW+FW:0] result,
    output logic          flag_ovf,
    output logic          flag_unf,
    output logic          flag_inv,
    output logic          flag_inx
);

    localparam int WW = EW + FW + 1;
    localparam logic [WW-2:0] INF_MAG = {{EW{1'b1}}, {FW{1'b0}}};
    localparam logic [WW-1:0] QNAN    = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

    logic          sa, sb;
    logic [EW-1:0] ea, eb;
    logic [FW:0]   ma, mb;
    fp_class_e     ca, cb;

    logic          big_sign, eff_sub;
    logic [EW-1:0] big_exp;
    logic [FW+FP_GRS_W:0] big_ext, small_ext;

    logic          c_sign, c_zero, c_ovf, c_unf, c_inx;
    logic [EW-1:0] c_exp;
    logic [FW-1:0] c_frac;

    logic [WW-1:0] nxt_res;
    fp_flags_t     nxt_flg;

    fpadd_classify #(.EW(EW), .FW(FW)) u_cls_a (
        .word_i(op_a), .negate_i(1'b0),
        .sign_o(sa), .exp_o(ea), .sig_o(ma), .cls_o(ca)
    );

    fpadd_classify #(.EW(EW), .FW(FW)) u_cls_b (
        .word_i(op_b), .negate_i(sub_en),
        .sign_o(sb), .exp_o(eb), .sig_o(mb), .cls_o(cb)
    );

    fpadd_align #(.EW(EW), .FW(FW)) u_align (
        .sign_a(sa), .exp_a(ea), .sig_a(ma),
        .sign_b(sb), .exp_b(eb), .sig_b(mb),
        .big_sign(big_sign), .big_exp(big_exp),
        .big_ext(big_ext), .small_ext(small_ext), .eff_sub(eff_sub)
    );

    fpadd_normround #(.EW(EW), .FW(FW)) u_normround (
        .eff_sub(eff_sub), .big_sign(big_sign), .big_exp(big_exp),
        .big_ext(big_ext), .small_ext(small_ext),
        .res_sign(c_sign), .res_exp(c_exp), .res_frac(c_frac),
        .exact_zero(c_zero), .ovf(c_ovf), .unf(c_unf), .inx(c_inx)
    );

    // special operands take priority over the arithmetic path
    always_comb begin
        nxt_flg = '0;
        if (ca == CLS_NAN || cb == CLS_NAN) begin
            nxt_res = QNAN;
        end else if (ca == CLS_INF && cb == CLS_INF) begin
            if (sa != sb) begin
                nxt_res     = QNAN;
                nxt_flg.inv = 1'b1;
            end else begin
                nxt_res = {sa, INF_MAG};
            end
        end else if (ca == CLS_INF) begin
            nxt_res = {sa, INF_MAG};
        end else if (cb == CLS_INF) begin
            nxt_res = {sb, INF_MAG};
        end else if (ca == CLS_ZERO && cb == CLS_ZERO) begin
            nxt_res = {sa & sb, {(WW-1){1'b0}}};
        end else if (ca == CLS_ZERO) begin
            nxt_res = {sb, eb, mb[FW-1:0]};
        end else if (cb == CLS_ZERO) begin
            nxt_res = {sa, ea, ma[FW-1:0]};
        end else if (c_zero) begin
            nxt_res = '0;
        end else if (c_ovf) begin
            nxt_res     = {c_sign, INF_MAG};
            nxt_flg.ovf = 1'b1;
            nxt_flg.inx = 1'b1;
        end else if (c_unf) begin
            nxt_res     = {c_sign, {(WW-1){1'b0}}};
            nxt_flg.unf = 1'b1;
            nxt_flg.inx = 1'b1;
        end else begin
            nxt_res     = {c_sign, c_exp, c_frac};
            nxt_flg.inx = c_inx;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            flag_ovf  <= 1'b0;
            flag_unf  <= 1'b0;
            flag_inv  <= 1'b0;
            flag_inx  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result   <= nxt_res;
                flag_ovf <= nxt_flg.ovf;
                flag_unf <= nxt_flg.unf;
                flag_inv <= nxt_flg.inv;
                flag_inx <= nxt_flg.inx;
            end
        end
    end

endmodule

// File: rtl/fp_addsub_chk.sv
module fp_addsub_chk #(
    parameter int EW = 8,
    parameter int FW = 23
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic          out_valid,
    input logic [EW+FW:0] result,
    input logic          flag_ovf,
    input logic          flag_unf,
    input logic          flag_inv,
    input logic          flag_inx
);

    localparam logic [EW+FW:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(FW-1){1'b0}}};

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    assert_ovf_inf_R5: assert property (@(posedge clk) disable iff (rst)
        flag_ovf |-> (result[EW+FW-1:FW] == {EW{1'b1}} && result[FW-1:0] == '0 && flag_inx));

    assert_unf_zero_R6: assert property (@(posedge clk) disable iff (rst)
        flag_unf |-> (result[EW+FW-1:0] == '0 && flag_inx));

    assert_no_subnormal_R6: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !(result[EW+FW-1:FW] == '0 && result[FW-1:0] != '0));

    assert_inv_nan_R8: assert property (@(posedge clk) disable iff (rst)
        flag_inv |-> (result == QNAN && !flag_inx));

    assert_flags_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flag_ovf, flag_unf, flag_inv}));

endmodule

bind fp_addsub fp_addsub_chk #(.EW(EW), .FW(FW)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .result(result), .flag_ovf(flag_ovf), .flag_unf(flag_unf),
    .flag_inv(flag_inv), .flag_inx(flag_inx)
);

// File: tb/fp_addsub_tb.sv
module fp_addsub_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic        sub_en = 1'b0;
    logic        out_valid;
    logic [31:0] result;
    logic        flag_ovf, flag_unf, flag_inv, flag_inx;

    int n_total = 0;
    int n_bad   = 0;
    logic [35:0] sb_q[$];
    string       tag_q[$];
    logic [31:0] last_res = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fp_addsub u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_a(op_a), .op_b(op_b), .sub_en(sub_en),
        .out_valid(out_valid), .result(result),
        .flag_ovf(flag_ovf), .flag_unf(flag_unf),
        .flag_inv(flag_inv), .flag_inx(flag_inx)
    );

    // flags packed as {ovf, unf, inv, inx}
    task automatic drive(input logic [31:0] a, input logic [31:0] b, input logic s,
                         input logic [31:0] er, input logic [3:0] ef, input string tag);
        @(negedge clk);
        op_a     = a;
        op_b     = b;
        sub_en   = s;
        in_valid = 1'b1;
        sb_q.push_back({er, ef});
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check(input logic ok, input string tag, input logic [35:0] act,
                         input logic [35:0] expv);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%h/%b expected=%h/%b", tag,
                     act[35:4], act[3:0], expv[35:4], expv[3:0]);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            logic [35:0] act;
            act = {result, flag_ovf, flag_unf, flag_inv, flag_inx};
            if (sb_q.size() == 0) begin
                check(1'b0, "R10 unexpected out_valid", act, 36'h0);
            end else begin
                logic [35:0] e;
                string t;
                e = sb_q.pop_front();
                t = tag_q.pop_front();
                check(act == e, t, act, e);
                last_res = e[35:4];
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0 && result == '0 &&
              {flag_ovf, flag_unf, flag_inv, flag_inx} == 4'b0,
              "R10 reset state", {result, flag_ovf, flag_unf, flag_inv, flag_inx}, 36'h0);
        rst = 1'b0;

        // R1 rounding to nearest even
        drive(32'h3FC00000, 32'h40200000, 1'b0, 32'h40800000, 4'b0000, "R1 1.5+2.5");
        drive(32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 4'b0001, "R1 above half ulp");
        drive(32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 4'b0001, "R1 tie even lsb");
        drive(32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 4'b0001, "R1 tie odd lsb");
        // R3 carries
        drive(32'h3F800000, 32'h3F800000, 1'b0, 32'h40000000, 4'b0000, "R3 1+1");
        drive(32'h3F800001, 32'h3F800000, 1'b0, 32'h40000000, 4'b0001, "R3 carry into guard");
        drive(32'h3FFFFFFF, 32'h33800000, 1'b0, 32'h40000000, 4'b0001, "R3 rounding renormalize");
        // R2 subtraction
        drive(32'h40000000, 32'h3FC00000, 1'b1, 32'h3F000000, 4'b0000, "R2 2-1.5");
        drive(32'h3F800001, 32'h3F800000, 1'b1, 32'h34000000, 4'b0000, "R2 deep cancel");
        drive(32'h3F800000, 32'hC0000000, 1'b0, 32'hBF800000, 4'b0000, "R2 mixed signs");
        drive(32'h3F800000, 32'h30800000, 1'b1, 32'h3F800000, 4'b0001, "R7 far sticky subtract");
        idle();
        idle();
        // R4 exact zero
        drive(32'h3F800000, 32'h3F800000, 1'b1, 32'h00000000, 4'b0000, "R4 1-1");
        drive(32'hBF800000, 32'h3F800000, 1'b0, 32'h00000000, 4'b0000, "R4 -1+1");
        // R5 overflow
        drive(32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 4'b1001, "R5 max+max");
        drive(32'hFF7FFFFF, 32'hFF7FFFFF, 1'b0, 32'hFF800000, 4'b1001, "R5 negative overflow");
        drive(32'h7F7FFFFF, 32'h73000000, 1'b0, 32'h7F800000, 4'b1001, "R5 rounding overflow");
        // R6 underflow and subnormal inputs
        drive(32'h00C00000, 32'h00800000, 1'b1, 32'h00000000, 4'b0101, "R6 underflow pos");
        drive(32'h80C00000, 32'h80800000, 1'b1, 32'h80000000, 4'b0101, "R6 underflow neg");
        drive(32'h00000001, 32'h3F800000, 1'b0, 32'h3F800000, 4'b0000, "R6 subnormal as zero");
        // R8 NaN / invalid
        drive(32'h7FC00001, 32'h3F800000, 1'b0, 32'h7FC00000, 4'b0000, "R8 quiet nan in");
        drive(32'h3F800000, 32'h7F800001, 1'b0, 32'h7FC00000, 4'b0000, "R8 signalling nan in");
        drive(32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 4'b0010, "R8 inf-inf");
        drive(32'h7F800000, 32'hFF800000, 1'b0, 32'h7FC00000, 4'b0010, "R8 inf+-inf");
        // R9 infinities and zeros
        drive(32'h7F800000, 32'h3F800000, 1'b0, 32'h7F800000, 4'b0000, "R9 inf+1");
        drive(32'h3F800000, 32'h7F800000, 1'b1, 32'hFF800000, 4'b0000, "R9 1-inf");
        drive(32'h7F800000, 32'h7F800000, 1'b0, 32'h7F800000, 4'b0000, "R9 inf+inf");
        drive(32'h00000000, 32'h40200000, 1'b1, 32'hC0200000, 4'b0000, "R9 0-2.5");
        drive(32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 4'b0000, "R9 -0+-0");
        drive(32'h00000000, 32'h80000000, 1'b0, 32'h00000000, 4'b0000, "R9 +0+-0");
        drive(32'h80000000, 32'h00000000, 1'b1, 32'h80000000, 4'b0000, "R9 -0-+0");
        idle();
        @(negedge clk);
        check(out_valid == 1'b0 && result == last_res, "R10 idle hold",
              {result, 4'b0}, {last_res, 4'b0});
        check(sb_q.size() == 0, "R10 all results returned",
              36'(sb_q.size()), 36'h0);
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

endmodule